// File: doc/BRIEF.md
# Transmit DMA Request Pin Generator

This block drives one active-low pin that serves either as a static modem "terminal ready" output or as a transmit DMA request. It holds a small transmit FIFO. A CPU or DMA engine writes bytes into the FIFO through a synchronous write strobe, and the serializer drains bytes from it through a pop port. A four-bit configuration register selects the pin function, the FIFO level that raises a request, and whether the request is released early or late around each write.

In request mode the pin goes low while the FIFO meets the selected threshold. This holds even when nothing is draining the FIFO. The pin goes high around each write strobe. After every transfer the pin stays high for one mandatory cycle before the FIFO state is looked at again. In modem mode the pin simply shows the inverse of the terminal-ready bit.

Top module: `txreq_pin_gen`

## Requirements
- R1: After hardware reset the pin is high, `rd_valid` is 0 and `overrun` is 0.
- R2: With config bit 1 (request mode) at 0, the pin equals the inverse of config bit 0 (terminal ready), from the clock edge that writes the register onward.
- R3: With request mode on and config bit 2 at 0, the pin is low in steady state whenever at least one FIFO slot is free. This includes the case where no byte is ever drained.
- R4: With request mode on and config bit 2 at 1, the pin is low in steady state only when the FIFO holds no byte.
- R5: With config bit 3 at 0 (late release), a low request stays low for every cycle the write strobe is held. It goes high on the edge that samples the strobe low.
- R6: With config bit 3 at 1 (early release), the pin is high from the edge that samples the first strobe cycle.
- R7: After a strobe ends, the pin is high for exactly one cycle. At the next edge the request is re-evaluated from the FIFO level.
- R8: A write stores `wr_data` as sampled on the first strobe cycle only. Bytes leave in write order on `rd_data`, and `rd_valid` is 1 while the FIFO is non-empty.
- R9: A write to a full FIFO (DEPTH bytes) is dropped and sets `overrun`. `overrun` stays set until a reset.
- R10: A channel reset pulse empties the FIFO, clears the configuration and `overrun`, and leaves the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 4 | Config: [3] early release, [2] all-empty threshold, [1] request mode, [0] terminal ready |
| wr_stb | input | 1 | Write strobe, active high, one or more cycles |
| wr_data | input | DATA_W | Byte to store on the first strobe cycle |
| rd_en | input | 1 | Pop request from the serializer |
| rd_data | output | DATA_W | Byte at the FIFO head |
| rd_valid | output | 1 | FIFO holds at least one byte |
| overrun | output | 1 | Sticky flag for a write dropped on a full FIFO |
| pin_n | output | 1 | Active-low request / terminal-ready pin |

## Verification
Configuration changes, FIFO pushes and pops, and the early or late release all appear at the outputs right after the single clock edge that samples them. The bench therefore reads these results a quarter period after that edge. A level request needs one more edge after the FIFO changes. A strobe that ends costs one gap cycle plus one evaluation edge. For this reason the random phase waits three cycles after each operation before it compares the pin with the level expected from the threshold. The directed sequences read the pin on each edge one by one, so the one-cycle gap and both release timings are checked exactly.

// File: rtl/txreq_pkg.sv
package txreq_pkg;

   localparam int CFG_W = 4;

   // bit order matches cfg_wdata: [3] early release, [2] all-empty threshold,
   // [1] request mode, [0] terminal ready
   typedef struct packed {
      logic fast_rel;
      logic thr_all;
      logic req_mode;
      logic dtr;
   } cfg_t;

   typedef enum logic [2:0] {
      RQ_IDLE,
      RQ_LOW,
      RQ_HOLD_LOW,
      RQ_HOLD_HIGH,
      RQ_GAP
   } rq_state_e;

endpackage

// File: rtl/txreq_cfg.sv
module txreq_cfg
   import txreq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output cfg_t             cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (chan_rst) begin
         cfg <= '0;
      end else if (cfg_we) begin
         cfg <= cfg_t'(cfg_wdata);
      end
   end

endmodule

// File: rtl/txreq_fifo.sv
module txreq_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  fill,
   output logic              ovr
);

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [DATA_W-1:0] slot_mem [DEPTH];
   logic              full, empty, do_push, do_pop;

   assign full    = (fill == CNT_W'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push_req & ~full;
   assign do_pop  = pop_req & ~empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk) begin
         if (do_push && (wr_ptr == PTR_W'(i))) begin
            byte_q <= push_data;
         end
      end
      assign slot_mem[i] = byte_q;
   end

   assign pop_data = slot_mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
         ovr    <= 1'b0;
      end else if (chan_rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
         ovr    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         unique case ({do_push, do_pop})
            2'b10:   fill <= fill + CNT_W'(1);
            2'b01:   fill <= fill - CNT_W'(1);
            default: fill <= fill;
         endcase
         if (push_req && full) ovr <= 1'b1;
      end
   end

endmodule

// File: rtl/txreq_timing.sv
module txreq_timing
   import txreq_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  cfg_t             cfg,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] fill,
   output logic             pin_n
);

   rq_state_e st, st_nxt;
   logic      want;

   assign want = cfg.req_mode &&
                 (cfg.thr_all ? (fill == '0) : (fill < CNT_W'(DEPTH)));

   always_comb begin
      st_nxt = st;
      if (!cfg.req_mode) begin
         st_nxt = RQ_IDLE;
      end else begin
         unique case (st)
            RQ_IDLE, RQ_GAP:
               st_nxt = wr_stb ? RQ_HOLD_HIGH : (want ? RQ_LOW : RQ_IDLE);
            RQ_LOW:
               if (wr_stb) st_nxt = cfg.fast_rel ? RQ_HOLD_HIGH : RQ_HOLD_LOW;
               else        st_nxt = want ? RQ_LOW : RQ_IDLE;
            RQ_HOLD_LOW, RQ_HOLD_HIGH:
               st_nxt = wr_stb ? st : RQ_GAP;
            default:
               st_nxt = RQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RQ_IDLE;
      end else if (chan_rst) begin
         st <= RQ_IDLE;
      end else begin
         st <= st_nxt;
      end
   end

   assign pin_n = cfg.req_mode ? !((st == RQ_LOW) || (st == RQ_HOLD_LOW))
                               : !cfg.dtr;

endmodule

// File: rtl/txreq_pin_gen.sv
module txreq_pin_gen
   import txreq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              overrun,
   output logic              pin_n
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("txreq_pin_gen: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("txreq_pin_gen: DATA_W must be positive");
   end

   cfg_t             cfg;
   logic             stb_q;
   logic             wr_first;
   logic [CNT_W-1:0] fill;
   logic             cfg_mode, cfg_fast;

   assign cfg_mode = cfg.req_mode;
   assign cfg_fast = cfg.fast_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stb_q <= 1'b0;
      else if (chan_rst) stb_q <= 1'b0;
      else               stb_q <= wr_stb;
   end

   assign wr_first = wr_stb & ~stb_q;

   txreq_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_rst  (chan_rst),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg       (cfg)
   );

   txreq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_rst  (chan_rst),
      .push_req  (wr_first),
      .push_data (wr_data),
      .pop_req   (rd_en),
      .pop_data  (rd_data),
      .fill      (fill),
      .ovr       (overrun)
   );

   txreq_timing #(.DEPTH(DEPTH)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_rst (chan_rst),
      .cfg      (cfg),
      .wr_stb   (wr_stb),
      .fill     (fill),
      .pin_n    (pin_n)
   );

   assign rd_valid = (fill != '0);

endmodule

// File: rtl/txreq_pin_gen_chk.sv
module txreq_pin_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_rst,
   input logic       cfg_we,
   input logic [3:0] cfg_wdata,
   input logic       wr_stb,
   input logic       rd_valid,
   input logic       overrun,
   input logic       pin_n,
   input logic       mode_r,
   input logic       fast_r
);

   assert_mode0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_wdata[1] && !chan_rst |=> pin_n == !$past(cfg_wdata[0]));

   assert_late_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_r && !fast_r && !pin_n && wr_stb && !cfg_we && !chan_rst |=> !pin_n);

   assert_early_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_r && fast_r && wr_stb && !$past(wr_stb) && !cfg_we && !chan_rst |=> pin_n);

   assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_r && $fell(wr_stb) && !cfg_we && !chan_rst |=> pin_n);

   assert_write_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !$past(wr_stb) && !chan_rst |=> rd_valid);

   assert_sticky_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !chan_rst |=> overrun);

   assert_chan_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> pin_n && !rd_valid && !overrun);

endmodule

bind txreq_pin_gen txreq_pin_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_rst  (chan_rst),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .wr_stb    (wr_stb),
   .rd_valid  (rd_valid),
   .overrun   (overrun),
   .pin_n     (pin_n),
   .mode_r    (cfg_mode),
   .fast_r    (cfg_fast)
);

// File: tb/txreq_pin_gen_tb.sv
module txreq_pin_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int DEPTH      = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chan_rst = 1'b0;
   logic              cfg_we = 1'b0;
   logic [3:0]        cfg_wdata = '0;
   logic              wr_stb = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid, overrun, pin_n;

   int                checks = 0;
   int                errors = 0;
   logic [DATA_W-1:0] q[$];
   logic              exp_ovr = 1'b0;
   logic              thr_sel = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txreq_pin_gen #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .overrun(overrun), .pin_n(pin_n)
   );

   task automatic cyc();
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_pin(int cnt, logic thr);
      return !(thr ? (cnt == 0) : (cnt < DEPTH));
   endfunction

   task automatic cfg_write(logic fast, logic thr, logic mode, logic dtr);
      cfg_we = 1'b1;
      cfg_wdata = {fast, thr, mode, dtr};
      thr_sel = thr;
      cyc();
      cfg_we = 1'b0;
   endtask

   // strobe held len cycles; the data bus changes after the first cycle
   task automatic do_write(logic [DATA_W-1:0] d, int len);
      wr_stb = 1'b1;
      wr_data = d;
      cyc();
      wr_data = ~d;
      for (int i = 1; i < len; i++) cyc();
      wr_stb = 1'b0;
      if (q.size() < DEPTH) q.push_back(d);
      else exp_ovr = 1'b1;
   endtask

   task automatic do_read();
      rd_en = 1'b1;
      cyc();
      rd_en = 1'b0;
      if (q.size() > 0) void'(q.pop_front());
   endtask

   task automatic check_fifo(string req);
      chk({req, " rd_valid"}, rd_valid, q.size() > 0);
      chk({req, " overrun"}, overrun, exp_ovr);
      if (q.size() > 0) chk({req, " rd_data"}, rd_data, q[0]);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) cyc();
      // R1 reset state
      chk("R1 pin", pin_n, 1'b1);
      chk("R1 rd_valid", rd_valid, 1'b0);
      chk("R1 overrun", overrun, 1'b0);
      rst_n = 1'b1;
      cyc();
      chk("R1 pin after release", pin_n, 1'b1);

      // R2 modem mode follows inverse of terminal-ready bit
      cfg_write(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R2 dtr=1", pin_n, 1'b0);
      cfg_write(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 dtr=0", pin_n, 1'b1);

      // R3 / R5 / R7 late release
      cfg_write(1'b0, 1'b0, 1'b1, 1'b0);
      cyc();
      chk("R3 empty request", pin_n, 1'b0);
      wr_stb = 1'b1; wr_data = 8'hA5;
      cyc();
      chk("R5 low in first strobe cycle", pin_n, 1'b0);
      wr_data = 8'h00;
      cyc();
      chk("R5 low while strobe held", pin_n, 1'b0);
      wr_stb = 1'b0;
      q.push_back(8'hA5);
      cyc();
      chk("R7 gap high", pin_n, 1'b1);
      cyc();
      chk("R7 reevaluated low", pin_n, 1'b0);

      // R6 early release
      cfg_write(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R6 still requested", pin_n, 1'b0);
      wr_stb = 1'b1; wr_data = 8'h3C;
      cyc();
      chk("R6 high at strobe start", pin_n, 1'b1);
      wr_stb = 1'b0;
      q.push_back(8'h3C);
      cyc();
      chk("R7 gap after early", pin_n, 1'b1);
      cyc();
      chk("R7 back low", pin_n, 1'b0);

      // R4 all-empty threshold
      cfg_write(1'b0, 1'b1, 1'b1, 1'b0);
      cyc(); cyc();
      chk("R4 high with two bytes", pin_n, 1'b1);
      check_fifo("R8 order first");
      do_read();
      check_fifo("R8 order second");
      chk("R4 high with one byte", pin_n, 1'b1);
      do_read();
      cyc();
      chk("R4 low when empty", pin_n, 1'b0);
      check_fifo("R8 drained");

      // R9 overrun and R3 full without draining
      cfg_write(1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         do_write(8'h10 + 8'(i), 1 + i % 2);
         cyc(); cyc();
      end
      cyc();
      chk("R3 full high", pin_n, 1'b1);
      do_write(8'hEE, 1);
      cyc();
      chk("R9 overrun set", overrun, 1'b1);
      while (q.size() > 0) begin
         check_fifo("R9 data kept");
         do_read();
      end
      cyc();
      check_fifo("R9 dropped byte absent");
      chk("R9 sticky", overrun, 1'b1);

      // R10 channel reset
      cfg_write(1'b0, 1'b0, 1'b1, 1'b1);
      do_write(8'h77, 1);
      chan_rst = 1'b1;
      cyc();
      chan_rst = 1'b0;
      q.delete();
      exp_ovr = 1'b0;
      chk("R10 pin high", pin_n, 1'b1);
      check_fifo("R10 cleared");
      cyc();
      chk("R10 config cleared", pin_n, 1'b1);

      // random phase: R3 R4 R8 R9 steady levels
      for (int blk = 0; blk < 6; blk++) begin
         cfg_write(1'($urandom_range(1)), 1'($urandom_range(1)), 1'b1, 1'b0);
         for (int n = 0; n < 40; n++) begin
            if ($urandom_range(2) != 0) do_write(8'($urandom), $urandom_range(1, 3));
            else do_read();
            repeat (3) cyc();
            chk(thr_sel ? "R4 random level" : "R3 random level",
                pin_n, exp_pin(q.size(), thr_sel));
            check_fifo("R8 random");
         end
      end

      finish_run();
   end

endmodule